// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

This block is a memory-mapped general-purpose I/O controller that groups its pins into banks (three banks of 32 pins by default). Pin n lives in bank n/32 at bit n%32. Each bank has its own direction, output data, input polarity and four per-pin interrupt-detection enables: rising edge, falling edge, high level and low level. Separate write-only set and clear registers let software change single output bits without a read-modify-write. The pad side is modelled as output-enable, output-value and input vectors. Every input passes through a two-flop synchroniser before it is read or used for detection.

Detected events land in a sticky per-bank status register that software clears by writing ones. The status bits of all banks are ORed into one shared interrupt line. Edge events set a status bit once per transition. A level condition keeps setting the bit for as long as the level lasts, so a clear has no lasting effect while the condition holds.

The register port is a plain single-cycle strobe bus with no back-pressure. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. A read returns its data on `bus_rdata` one clock after the strobe, and the value is held until the next read. The address is split into a 4-bit function group (`bus_addr[7:4]`) and a bank index (`bus_addr[3:2]`). The pads are plain control and status pins.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero: `pad_oe`, `pad_out` and `irq` are 0, and with all pads low every mapped read returns 0.
- R2: A register's address is function-group code × 16 + bank × 4. The group codes are 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rise enable, 6 fall enable, 7 high enable, 8 low enable, 9 status and 10 edge view. Addresses with a group above 10, a bank index of NUM_BANKS or more, or nonzero `bus_addr[1:0]` read as 0, and writes to them change nothing.
- R3: A 1 in a bank's direction bit drives `pad_oe` high for that pin, and `pad_out` shows that pin's data bit. A 0 makes the pin an input.
- R4: Writing the set register forces to 1 each data bit written as 1. Writing the clear register forces to 0 each data bit written as 1. Bits written as 0 keep their value, and both registers read as 0.
- R5: A read of the data register returns the driven data bit for output pins. For input pins it returns the pad value after the synchroniser, which appears on the third read strobe issued from the cycle in which the pad changes (two flops plus the read register).
- R6: A 1 in the polarity register inverts that pin's input, both as read from the data register and as seen by interrupt detection.
- R7: With the rise enable set, a 0→1 input transition sets the pin's status bit. With the fall enable set, a 1→0 transition sets it. With both set, either transition sets it. No status bit becomes set unless one of that pin's enables was set.
- R8: With the high (low) enable set, the status bit is set while the input is 1 (0) and stays set across clear writes for as long as the level persists.
- R9: Writing 1 to a status bit clears it, and bits written as 0 keep their value. Status bits stay set until cleared.
- R10: `irq` is high exactly when any status bit of any bank is set. It rises on the third clock edge after a pad change that causes an enabled event.
- R11: The edge-view register (group 10) reads as the bank's status masked by the pin's rise or fall enable. It is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: group in [7:4], bank in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| pad_in | input | 96 | Pad input values, bank-major |
| pad_oe | output | 96 | Pad output enables (the direction bits) |
| pad_out | output | 96 | Pad output values |
| irq | output | 1 | Shared interrupt: OR of all status bits |

## Verification
Each of the five detection modes is run on pins at the low end, the middle and the high end of every bank. Each run walks the pin through low, high and low again, with a clear after every step. This separates edge behaviour (status set once, gone after a clear) from level behaviour (status reappears after a clear). It also shows that no pin or bank other than the one under test is touched. The output path is tried with distinct per-bank patterns and masked set and clear writes. The input path is read cycle by cycle after a pad change, with and without polarity inversion, to pin down the synchroniser depth. A sweep over all group and bank addresses, plus writes to unmapped addresses, confirms the reset values and the decode.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  typedef enum logic [3:0] {
    FN_DIR  = 4'd0,
    FN_POL  = 4'd1,
    FN_DATA = 4'd2,
    FN_DSET = 4'd3,
    FN_DCLR = 4'd4,
    FN_RISE = 4'd5,
    FN_FALL = 4'd6,
    FN_HIGH = 4'd7,
    FN_LOW  = 4'd8,
    FN_STAT = 4'd9,
    FN_EDGE = 4'd10
  } gpio_fn_e;

  localparam int unsigned FN_LAST = 10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  gpio_fn_e          fn,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] rdata,
  input  logic [BANK_W-1:0] pad_in,
  output logic [BANK_W-1:0] pad_oe,
  output logic [BANK_W-1:0] pad_out,
  output logic              pending
);
  logic [BANK_W-1:0] dir_q, pol_q, dout_q;
  logic [BANK_W-1:0] ren_q, fen_q, hen_q, len_q;
  logic [BANK_W-1:0] stat_q, prev_q;
  logic [BANK_W-1:0] sync_in, eff_in, cause, w1c;

  gpio_sync #(.WIDTH(BANK_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (sync_in)
  );

  assign eff_in = sync_in ^ pol_q;
  assign cause  = (ren_q & eff_in & ~prev_q) | (fen_q & ~eff_in & prev_q)
                | (hen_q & eff_in) | (len_q & ~eff_in);
  assign w1c    = (wr_en && fn == FN_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      pol_q  <= '0;
      dout_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      hen_q  <= '0;
      len_q  <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= eff_in;
      stat_q <= (stat_q & ~w1c) | cause;
      if (wr_en) begin
        case (fn)
          FN_DIR:  dir_q  <= wdata;
          FN_POL:  pol_q  <= wdata;
          FN_DATA: dout_q <= wdata;
          FN_DSET: dout_q <= dout_q | wdata;
          FN_DCLR: dout_q <= dout_q & ~wdata;
          FN_RISE: ren_q  <= wdata;
          FN_FALL: fen_q  <= wdata;
          FN_HIGH: hen_q  <= wdata;
          FN_LOW:  len_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (fn)
      FN_DIR:  rdata = dir_q;
      FN_POL:  rdata = pol_q;
      FN_DATA: rdata = (dir_q & dout_q) | (~dir_q & eff_in);
      FN_RISE: rdata = ren_q;
      FN_FALL: rdata = fen_q;
      FN_HIGH: rdata = hen_q;
      FN_LOW:  rdata = len_q;
      FN_STAT: rdata = stat_q;
      FN_EDGE: rdata = stat_q & (ren_q | fen_q);
      default: rdata = '0;
    endcase
  end

  assign pad_oe  = dir_q;
  assign pad_out = dout_q;
  assign pending = |stat_q;

  AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn == FN_DSET) |=> ((dout_q & $past(wdata)) == $past(wdata))); // R4
  AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn == FN_DCLR) |=> ((dout_q & $past(wdata)) == '0)); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && fn == FN_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9
  AST_NO_CAUSE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(ren_q | fen_q | hen_q | len_q)) == '0)); // R7
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [7:0]                    bus_addr,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
  output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
  output logic                          irq
);
  localparam int unsigned BSEL_W = 2;

  gpio_fn_e          addr_fn;
  logic [BSEL_W-1:0] addr_bank;
  logic              mapped;
  logic [BANK_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;
  logic [BANK_W-1:0] sel_rd;

  assign addr_fn   = gpio_fn_e'(bus_addr[7:4]);
  assign addr_bank = bus_addr[3:2];
  assign mapped    = (bus_addr[7:4] <= 4'(FN_LAST))
                   && ({1'b0, addr_bank} < 3'(NUM_BANKS))
                   && (bus_addr[1:0] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_en && bus_we && mapped && addr_bank == BSEL_W'(b)),
      .fn     (addr_fn),
      .wdata  (bus_wdata),
      .rdata  (bank_rd[b]),
      .pad_in (pad_in[b*BANK_W +: BANK_W]),
      .pad_oe (pad_oe[b*BANK_W +: BANK_W]),
      .pad_out(pad_out[b*BANK_W +: BANK_W]),
      .pending(bank_pend[b])
    );
  end

  always_comb begin
    sel_rd = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (addr_bank == BSEL_W'(b)) sel_rd = bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= mapped ? sel_rd : '0;
  end

  assign irq = |bank_pend;

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !mapped) |=> (bus_rdata == '0)); // R2
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int W  = 32;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [NB*W-1:0] pad_in = '0, pad_oe, pad_out;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .BANK_W(W)) i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ad(input int fn, input int bank);
    return 8'(fn * 16 + bank * 4);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, exp, dirv, polv, inv, pat;
    int pins[3];
    pins[0] = 0; pins[1] = 17; pins[2] = 31;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state, R2 decode sweep
    chk(pad_oe == '0 && pad_out == '0, "R1 pads after reset", pad_oe[W-1:0], '0);
    chk(irq == 0, "R1 irq after reset", {31'b0, irq}, '0);
    for (int f = 0; f < 16; f++)
      for (int b = 0; b < 4; b++) begin
        rd(ad(f, b), r);
        chk(r == '0, "R1 R2 reset read", r, '0);
      end

    // R3 R4 outputs per bank
    for (int b = 0; b < NB; b++) begin
      pat = 32'h1357_9BDF * (b + 3);
      wr(ad(0, b), '1);
      wr(ad(2, b), pat);
      chk(pad_oe[b*W +: W] == '1, "R3 oe follows direction", pad_oe[b*W +: W], '1);
      chk(pad_out[b*W +: W] == pat, "R3 out follows data", pad_out[b*W +: W], pat);
      wr(ad(3, b), 32'h0000_F0F0);
      exp = pat | 32'h0000_F0F0;
      chk(pad_out[b*W +: W] == exp, "R4 set register", pad_out[b*W +: W], exp);
      wr(ad(4, b), 32'hFF00_0F00);
      exp = exp & ~32'hFF00_0F00;
      chk(pad_out[b*W +: W] == exp, "R4 clear register", pad_out[b*W +: W], exp);
      rd(ad(2, b), r);
      chk(r == exp, "R5 output readback", r, exp);
      rd(ad(3, b), r);
      chk(r == '0, "R4 set reads zero", r, '0);
      rd(ad(4, b), r);
      chk(r == '0, "R4 clear reads zero", r, '0);
    end

    // R5 R6 input path, synchroniser depth, polarity
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < 2; p++) begin
        dirv = 32'hFFFF_0000;
        polv = p ? 32'h00FF_00FF : 32'h0;
        wr(ad(0, b), dirv);
        wr(ad(2, b), 32'hABCD_0000);
        wr(ad(1, b), polv);
        inv = 32'h0000_5A3C ^ (b * 32'h111);
        pad_in[b*W +: W] = 32'h0;
        idle(3);
        rd(ad(2, b), r);
        exp = (dirv & 32'hABCD_0000) | (~dirv & polv);
        chk(r == exp, "R6 settled input with polarity", r, exp);
        pad_in[b*W +: W] = inv;
        rd(ad(2, b), r);
        chk(r == exp, "R5 first read after change is old", r, exp);
        rd(ad(2, b), r);
        chk(r == exp, "R5 second read after change is old", r, exp);
        rd(ad(2, b), r);
        exp = (dirv & 32'hABCD_0000) | (~dirv & (inv ^ polv));
        chk(r == exp, "R5 R6 third read shows new input", r, exp);
      end
      wr(ad(1, b), '0);
      wr(ad(0, b), '0);
      pad_in[b*W +: W] = '0;
    end
    idle(4);

    // R2 unmapped writes have no effect
    wr(8'h0C, '1);
    wr(8'hB0, '1);
    wr(8'h01, '1);
    chk(pad_oe == '0, "R2 unmapped writes ignored", pad_oe[W-1:0], '0);
    rd(8'h01, r);
    chk(r == '0, "R2 misaligned read zero", r, '0);

    // R7 R8 R9 R10 R11 mode sweep
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 3; k++)
        for (int mode = 0; mode < 5; mode++) begin
          logic [W-1:0] m, ea, eb, cb, ec, cc;
          bit ri, fa, hi, lo;
          m  = 32'h1 << pins[k];
          ri = (mode == 0 || mode == 2);
          fa = (mode == 1 || mode == 2);
          hi = (mode == 3);
          lo = (mode == 4);
          wr(ad(9, b), '1);
          wr(ad(5, b), ri ? m : '0);
          wr(ad(6, b), fa ? m : '0);
          wr(ad(7, b), hi ? m : '0);
          wr(ad(8, b), lo ? m : '0);
          idle(4);
          ea = lo ? m : '0;
          rd(ad(9, b), r);
          chk(r == ea, "R8 low level at start", r, ea);
          pad_in[b*W + pins[k]] = 1'b1;
          idle(4);
          eb = (lo || ri || hi) ? m : '0;
          rd(ad(9, b), r);
          chk(r == eb, "R7 R8 status after rise", r, eb);
          chk(irq == (eb != 0), "R10 irq after rise", {31'b0, irq}, {31'b0, eb != 0});
          rd(ad(10, b), r);
          exp = ri ? m : '0;
          chk(r == exp, "R11 edge view", r, exp);
          wr(ad(9, b), m);
          cb = hi ? m : '0;
          rd(ad(9, b), r);
          chk(r == cb, "R8 R9 after clear high", r, cb);
          pad_in[b*W + pins[k]] = 1'b0;
          idle(4);
          ec = (hi || fa || lo) ? m : '0;
          rd(ad(9, b), r);
          chk(r == ec, "R7 R8 status after fall", r, ec);
          wr(ad(9, b), m);
          cc = lo ? m : '0;
          rd(ad(9, b), r);
          chk(r == cc, "R8 R9 after clear low", r, cc);
          for (int g = 5; g < 9; g++) wr(ad(g, b), '0);
          wr(ad(9, b), '1);
          rd(ad(9, b), r);
          chk(r == '0, "R9 final clear", r, '0);
        end

    // R9 write-0 keeps other bits
    wr(ad(5, 0), 32'h24);
    pad_in[2] = 1; pad_in[5] = 1;
    idle(4);
    wr(ad(9, 0), 32'h4);
    rd(ad(9, 0), r);
    chk(r == 32'h20, "R9 zero bits keep status", r, 32'h20);
    wr(ad(9, 0), 32'h20);
    wr(ad(5, 0), '0);
    pad_in[2] = 0; pad_in[5] = 0;

    // R10 exact irq latency on bank 2
    wr(ad(5, 2), 32'h10);
    idle(4);
    chk(irq == 0, "R10 irq idle", {31'b0, irq}, '0);
    pad_in[2*W + 4] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(irq == 0, "R10 irq not before third edge", {31'b0, irq}, '0);
    @(negedge clk);
    chk(irq == 1, "R10 irq on third edge", {31'b0, irq}, 32'h1);
    wr(ad(9, 2), '1);
    chk(irq == 0, "R9 R10 irq drops after clear", {31'b0, irq}, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule